// File: doc/BRIEF.md
# Parallel Port Enhanced Cycle Controller

This block is the host end of an enhanced-mode parallel port. Each request accepted on the host side becomes exactly one address cycle or one data cycle on the peripheral side. The request carries a read/write direction, an address/data select and a byte of write data. Completion comes back as a response that carries the read byte and a timeout bit. The peripheral bus is an 8-bit bidirectional byte lane, given as separate out, in and output-enable signals, plus active-low write, data-strobe, address-strobe and wait lines.

A peripheral that holds the wait line low stretches the cycle. The strobe stays asserted until the two-flop synchronized copy of wait is seen high. Read data is captured on that same clock edge, and the strobe goes high on the next cycle. A counter starts when the strobe falls and ends a cycle that has stalled. In that case the strobe and the byte lane are released, the response returns 0xFF with its timeout bit set, and a sticky flag records the event until the host clears it.

Both host-side transfers use valid/ready. A request is taken only on a cycle where `req_valid` and `req_ready` are both high, and `req_ready` is high only while the controller is idle. A response is offered with `rsp_valid` and stays unchanged until `rsp_ready` is seen high, so the host can apply back-pressure for as long as it needs.

Top module: `epp_cycle_ctrl`

## Requirements
- R1: When idle, both strobes are high, `pd_oe` is 0, `req_ready` is 1 and `n_write` equals `req_rd`.
- R2: A request is accepted only while idle. `req_ready` stays 0 from acceptance until the response is consumed. `req_valid` has no effect during that time: it produces no extra strobe and no extra response.
- R3: Each cycle drives exactly one strobe low. `n_astb` is used when `req_addr`=1, `n_dstb` when `req_addr`=0, and the two are never low together.
- R4: On a write (`req_rd`=0), `n_write` is 0, and `pd_oe`=1 with `pd_out` equal to the write byte. These hold from at least one clock before the strobe falls until the response is consumed.
- R5: On a read (`req_rd`=1), `n_write` stays 1 and `pd_oe` stays 0. The byte on `pd_in` at the edge where synchronized wait is high is returned in `rsp_rdata`.
- R6: The strobe stays low for as long as the synchronized wait is low. It rises only after `n_wait` has been high for the two synchronizer stages.
- R7: If wait stays low, the strobe is low for exactly TMO_CYCLES clocks and the cycle is then aborted. The strobe rises, `pd_oe` goes to 0, and the response carries `rsp_timeout`=1 and `rsp_rdata`=0xFF.
- R8: `tmo_flag` is set together with an aborted response and stays set through later good cycles. A `tmo_clr` pulse clears it, and a set in the same cycle wins over the clear.
- R9: While `rsp_valid`=1 and `rsp_ready`=0, the response stays valid and `rsp_rdata`/`rsp_timeout` stay stable.
- R10: A write that completes normally responds with `rsp_timeout`=0 and `rsp_rdata`=0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_addr | input | 1 | 1 = address cycle, 0 = data cycle |
| req_rd | input | 1 | 1 = read, 0 = write; also sets idle `n_write` |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | Response offered |
| rsp_ready | input | 1 | Host takes response |
| rsp_rdata | output | 8 | Read byte, 0x00 after a write, 0xFF after abort |
| rsp_timeout | output | 1 | Cycle was aborted |
| tmo_flag | output | 1 | Sticky timeout status |
| tmo_clr | input | 1 | Clears `tmo_flag` |
| pd_out | output | 8 | Byte lane driven value |
| pd_oe | output | 1 | Byte lane output enable |
| pd_in | input | 8 | Byte lane sampled value |
| n_write | output | 1 | Active-low write indication |
| n_dstb | output | 1 | Active-low data strobe |
| n_astb | output | 1 | Active-low address strobe |
| n_wait | input | 1 | Peripheral wait, low = not ready |

## Verification
The hardest condition to reach from the ports is a request that arrives while the controller is busy, combined with a response the host is not yet taking. The bench produces it with a peripheral model whose reply delay is set per cycle. It keeps a second, different request on the host port through the first cycle's strobe phase, and the monitor holds `rsp_ready` low for a set number of clocks. Strobe falls and responses are counted to show the stray request left no trace. The abort path is reached by setting the model's delay beyond the timeout, with a short timeout so the exact strobe width can be measured.

// File: rtl/epp_pkg.sv
package epp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_STROBE = 2'd2,
    ST_HOLD   = 2'd3
  } epp_state_e;
endpackage

// File: rtl/epp_wait_sync.sv
// Multi-stage synchronizer for the peripheral wait line.
module epp_wait_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sh <= '0;
        else        sh <= din;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-2:0], din};
    end
  endgenerate

  assign dout = sh[STAGES-1];
endmodule

// File: rtl/epp_tmo_timer.sv
// Counts clocks while the strobe is active; flags the last permitted clock.
module epp_tmo_timer #(
  parameter int TMO_CYCLES = 1250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(TMO_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(TMO_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!run)       cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign expired = run && (cnt == LAST);
endmodule

// File: rtl/epp_cycle_fsm.sv
// Sequencer for one address or data cycle on the byte lane.
module epp_cycle_fsm
  import epp_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_addr,
  input  logic          req_rd,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_timeout,
  output logic [DW-1:0] pd_out,
  output logic          pd_oe,
  input  logic [DW-1:0] pd_in,
  output logic          n_write,
  output logic          n_dstb,
  output logic          n_astb,
  input  logic          wait_hi,
  input  logic          tmo_expired,
  output logic          strobe_on,
  output logic          abort_evt
);
  localparam logic [DW-1:0] FILL_ABORT = '1;
  localparam logic [DW-1:0] FILL_WRITE = '0;

  epp_state_e    st, st_nx;
  logic          cyc_addr, cyc_rd, cyc_tmo;
  logic [DW-1:0] cyc_wd, cyc_rd_byte;
  logic          take, done_ok;

  assign take      = (st == ST_IDLE) && req_valid;
  assign strobe_on = (st == ST_STROBE);
  assign done_ok   = strobe_on && wait_hi;
  assign abort_evt = strobe_on && !wait_hi && tmo_expired;

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE:   if (req_valid) st_nx = ST_SETUP;
      ST_SETUP:  st_nx = ST_STROBE;
      ST_STROBE: if (done_ok || abort_evt) st_nx = ST_HOLD;
      ST_HOLD:   if (rsp_ready) st_nx = ST_IDLE;
      default:   st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      cyc_addr    <= 1'b0;
      cyc_rd      <= 1'b1;
      cyc_wd      <= '0;
      cyc_tmo     <= 1'b0;
      cyc_rd_byte <= '0;
    end else begin
      st <= st_nx;
      if (take) begin
        cyc_addr <= req_addr;
        cyc_rd   <= req_rd;
        cyc_wd   <= req_wdata;
        cyc_tmo  <= 1'b0;
      end
      if (done_ok) begin
        cyc_rd_byte <= cyc_rd ? pd_in : FILL_WRITE;
      end else if (abort_evt) begin
        cyc_rd_byte <= FILL_ABORT;
        cyc_tmo     <= 1'b1;
      end
    end
  end

  assign req_ready   = (st == ST_IDLE);
  assign rsp_valid   = (st == ST_HOLD);
  assign rsp_rdata   = cyc_rd_byte;
  assign rsp_timeout = cyc_tmo;

  assign n_write = (st == ST_IDLE) ? req_rd : cyc_rd;
  assign pd_out  = cyc_wd;
  always_comb begin
    unique case (st)
      ST_SETUP, ST_STROBE: pd_oe = !cyc_rd;
      ST_HOLD:             pd_oe = !cyc_rd && !cyc_tmo;
      default:             pd_oe = 1'b0;
    endcase
  end

  assign n_astb = !(strobe_on && cyc_addr);
  assign n_dstb = !(strobe_on && !cyc_addr);
endmodule

// File: rtl/epp_cycle_ctrl.sv
module epp_cycle_ctrl #(
  parameter int DW          = 8,
  parameter int TMO_CYCLES  = 1250,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_addr,
  input  logic          req_rd,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_timeout,
  output logic          tmo_flag,
  input  logic          tmo_clr,
  output logic [DW-1:0] pd_out,
  output logic          pd_oe,
  input  logic [DW-1:0] pd_in,
  output logic          n_write,
  output logic          n_dstb,
  output logic          n_astb,
  input  logic          n_wait
);
  logic wait_hi, tmo_expired, strobe_on, abort_evt;

  epp_wait_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .din(n_wait), .dout(wait_hi)
  );

  epp_tmo_timer #(.TMO_CYCLES(TMO_CYCLES)) timer_i (
    .clk(clk), .rst_n(rst_n), .run(strobe_on), .expired(tmo_expired)
  );

  epp_cycle_fsm #(.DW(DW)) fsm_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_rd(req_rd), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rsp_timeout(rsp_timeout),
    .pd_out(pd_out), .pd_oe(pd_oe), .pd_in(pd_in),
    .n_write(n_write), .n_dstb(n_dstb), .n_astb(n_astb),
    .wait_hi(wait_hi), .tmo_expired(tmo_expired),
    .strobe_on(strobe_on), .abort_evt(abort_evt)
  );

  // Sticky status: a set in the same cycle as a clear wins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         tmo_flag <= 1'b0;
    else if (abort_evt) tmo_flag <= 1'b1;
    else if (tmo_clr)   tmo_flag <= 1'b0;
  end
endmodule

// File: rtl/epp_cycle_ctrl_chk.sv
module epp_cycle_ctrl_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          req_rd,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [DW-1:0] rsp_rdata,
  input logic          rsp_timeout,
  input logic          tmo_flag,
  input logic          pd_oe,
  input logic          n_write,
  input logic          n_dstb,
  input logic          n_astb
);
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!n_dstb && !n_astb)); // R3

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (n_dstb && n_astb && !pd_oe && (n_write == req_rd))); // R1

  AST_READ_LANE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    n_write |-> !pd_oe); // R5

  AST_WRITE_LANE_ON: assert property (@(posedge clk) disable iff (!rst_n)
    ((!n_dstb || !n_astb) && !n_write) |-> pd_oe); // R4

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (!n_dstb || !n_astb || rsp_valid) |-> !req_ready); // R2

  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_timeout))); // R9

  AST_FLAG_SET_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_flag) |-> (rsp_valid && rsp_timeout)); // R8

  AST_ABORT_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_timeout) |-> (rsp_rdata == '1 && !pd_oe)); // R7
endmodule

bind epp_cycle_ctrl epp_cycle_ctrl_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .req_rd(req_rd),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
  .rsp_timeout(rsp_timeout), .tmo_flag(tmo_flag), .pd_oe(pd_oe),
  .n_write(n_write), .n_dstb(n_dstb), .n_astb(n_astb)
);

// File: tb/epp_cycle_ctrl_tb_top.sv
module epp_cycle_ctrl_tb_top;
  localparam int TMO = 50;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0, req_addr = 1'b0, req_rd = 1'b1;
  logic [7:0] req_wdata = 8'h00;
  logic       rsp_ready = 1'b0;
  logic       tmo_clr = 1'b0;
  logic [7:0] pd_in = 8'h00;
  logic       n_wait = 1'b0;
  logic       req_ready, rsp_valid, rsp_timeout, tmo_flag, pd_oe;
  logic       n_write, n_dstb, n_astb;
  logic [7:0] rsp_rdata, pd_out;

  always #4 clk = ~clk;

  epp_cycle_ctrl #(.DW(8), .TMO_CYCLES(TMO), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_rd(req_rd), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rsp_timeout(rsp_timeout), .tmo_flag(tmo_flag), .tmo_clr(tmo_clr),
    .pd_out(pd_out), .pd_oe(pd_oe), .pd_in(pd_in),
    .n_write(n_write), .n_dstb(n_dstb), .n_astb(n_astb), .n_wait(n_wait)
  );

  int checks = 0, errors = 0;
  int cycle_ct = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Scoreboard item: {timeout, oe, rdata, lane byte}
  logic [17:0] exp_q[$];
  int  cur_bp = 0;
  int  rsp_seen = 0;

  // Peripheral model state
  int  p_dly = 0;
  int  p_cnt = 0;
  int  last_len = 0;
  int  strobe_falls = 0;
  bit  prev_oe = 0;
  bit  e_addr = 0, e_rd = 0;
  logic [7:0] e_wd = 8'h00;

  always @(negedge clk) begin
    if (rst_n && (!n_dstb || !n_astb)) begin
      if (p_cnt == 0) begin
        strobe_falls++;
        chk(e_addr ? (!n_astb && n_dstb) : (!n_dstb && n_astb), "R3 strobe select",
            {n_astb, n_dstb}, e_addr ? 1 : 2);
        chk(n_write == e_rd, "R4/R5 n_write", n_write, e_rd);
        if (!e_rd) begin
          chk(prev_oe && pd_oe && pd_out == e_wd, "R4 lane before strobe",
              {prev_oe, pd_oe, pd_out}, {2'b11, e_wd});
        end else begin
          chk(!pd_oe, "R5 lane released", pd_oe, 0);
        end
      end
      p_cnt++;
      if (p_cnt >= p_dly) n_wait = 1'b1;
    end else begin
      if (p_cnt != 0) last_len = p_cnt;
      p_cnt = 0;
      n_wait = 1'b0;
    end
    prev_oe = pd_oe;
  end

  // Response monitor with back-pressure.
  always begin
    @(negedge clk);
    if (rst_n && rsp_valid) begin
      logic [7:0] first_rd;
      logic [17:0] e;
      first_rd = rsp_rdata;
      for (int i = 0; i < cur_bp; i++) begin
        @(negedge clk);
        chk(rsp_valid && rsp_rdata == first_rd, "R9 response held",
            {rsp_valid, rsp_rdata}, {1'b1, first_rd});
      end
      rsp_seen++;
      if (exp_q.size() == 0) begin
        chk(0, "R2 unexpected response", rsp_rdata, 0);
      end else begin
        e = exp_q.pop_front();
        chk(rsp_timeout == e[17], "R7/R10 rsp_timeout", rsp_timeout, e[17]);
        chk(rsp_rdata == e[15:8], "R5/R7/R10 rsp_rdata", rsp_rdata, e[15:8]);
        chk(pd_oe == e[16] && (!e[16] || pd_out == e[7:0]), "R4/R7 lane at response",
            {pd_oe, pd_out}, {e[16], e[7:0]});
        chk(!req_ready, "R2 busy until consumed", req_ready, 0);
      end
      rsp_ready = 1'b1;
      @(negedge clk);
      rsp_ready = 1'b0;
    end
  end

  task automatic run_cycle(input bit addr, input bit rd, input logic [7:0] wd,
                           input logic [7:0] pd, input int dly, input int bp,
                           input bit tmo, input int junk);
    logic [7:0] erd;
    bit eoe;
    while (!req_ready || exp_q.size() != 0) @(negedge clk);
    erd = tmo ? 8'hFF : (rd ? pd : 8'h00);
    eoe = !rd && !tmo;
    exp_q.push_back({tmo, eoe, erd, wd});
    p_dly = dly; cur_bp = bp; pd_in = pd;
    e_addr = addr; e_rd = rd; e_wd = wd;
    req_valid = 1'b1; req_addr = addr; req_rd = rd; req_wdata = wd;
    @(negedge clk);
    if (junk > 0) begin
      req_addr = !addr; req_wdata = ~wd;
      for (int i = 0; i < junk; i++) begin
        chk(!req_ready, "R2 not ready while busy", req_ready, 0);
        @(negedge clk);
      end
    end
    req_valid = 1'b0;
    req_addr = addr; req_wdata = wd;
    while (exp_q.size() != 0 || !req_ready) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    int falls_before, seen_before;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset and idle
    chk(req_ready && n_dstb && n_astb && !pd_oe && !rsp_valid && !tmo_flag,
        "R1 reset state", {req_ready, n_dstb, n_astb, pd_oe, rsp_valid, tmo_flag}, 6'b111000);
    req_rd = 1'b0; #1;
    chk(n_write == 1'b0, "R1 idle n_write follows dir", n_write, 0);
    req_rd = 1'b1; #1;
    chk(n_write == 1'b1, "R1 idle n_write follows dir", n_write, 1);

    run_cycle(0, 0, 8'hA5, 8'h00, 3, 0, 0, 0);  // R4 R10 data write
    run_cycle(1, 0, 8'h3C, 8'h00, 0, 0, 0, 0);  // R3 address write
    run_cycle(0, 1, 8'h00, 8'h5A, 5, 0, 0, 0);  // R5 data read
    run_cycle(1, 1, 8'h00, 8'hC3, 2, 0, 0, 0);  // R5 address read
    run_cycle(0, 0, 8'h81, 8'h00, 1, 4, 0, 0);  // R9 back-pressure on write
    run_cycle(0, 1, 8'h00, 8'h96, 2, 3, 0, 0);  // R9 back-pressure on read

    // R6 long wait below the timeout
    run_cycle(0, 1, 8'h00, 8'h17, 30, 0, 0, 0);
    chk(last_len >= 32, "R6 strobe held while wait low", last_len, 32);
    chk(!tmo_flag, "R6 no timeout flag", tmo_flag, 0);

    // R2 stray request during a busy cycle
    falls_before = strobe_falls; seen_before = rsp_seen;
    run_cycle(0, 0, 8'h42, 8'h00, 6, 2, 0, 3);
    repeat (6) @(negedge clk);
    chk(strobe_falls == falls_before + 1, "R2 one strobe only", strobe_falls, falls_before + 1);
    chk(rsp_seen == seen_before + 1, "R2 one response only", rsp_seen, seen_before + 1);

    // R7 timeout on a write, then R8 flag
    run_cycle(0, 0, 8'hE7, 8'h00, 1000000, 0, 1, 0);
    chk(last_len == TMO, "R7 strobe width at abort", last_len, TMO);
    chk(tmo_flag, "R8 flag set after abort", tmo_flag, 1);
    // R7 timeout on an address read
    run_cycle(1, 1, 8'h00, 8'h11, 1000000, 2, 1, 0);
    chk(last_len == TMO, "R7 strobe width at read abort", last_len, TMO);
    // R8 sticky through a good cycle
    run_cycle(0, 1, 8'h00, 8'h6B, 1, 0, 0, 0);
    chk(tmo_flag, "R8 flag sticky", tmo_flag, 1);
    tmo_clr = 1'b1; @(negedge clk); tmo_clr = 1'b0; @(negedge clk);
    chk(!tmo_flag, "R8 flag cleared", tmo_flag, 0);
    chk(req_ready && n_dstb && n_astb && !pd_oe, "R1 idle after run",
        {req_ready, n_dstb, n_astb, pd_oe}, 4'b1110);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycle_ct++;
    if (cycle_ct > 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycle_ct, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule